// File: doc/BRIEF.md
# CAM Bus Manual Access Controller

This block decides who owns the control lines and data bus of an external content-addressable memory. The bus has four active-low control lines (chain enable, command mode, write enable, chip enable) and a 16-bit data path, split here into a drive value, a drive enable and a sampled input. In normal operation a small sequencer drives the lines on behalf of an automatic search engine. For each request it produces one timed access. The length of the chip-enable strobe comes from a 6-bit speed code.

A host on a simple register bus can take the bus over. Setting the manual-enable bit in the control register hands the four lines straight to bits 3:0 of that register. The host then toggles the lines one write at a time. A typical command write loads the data register, then writes control 19h, 11h and 19h: chip enable high, then low, then high. During a manual read, the bus value present when chip enable rises is captured into one of two 16-bit status halves, so a 32-bit device status needs two read cycles.

The sequencer has four states. `SQ_IDLE` goes to `SQ_SETUP` when a request arrives and manual mode is off. `SQ_SETUP` goes to `SQ_STROBE` after one cycle. `SQ_STROBE` goes to `SQ_HOLD` once its down-counter reaches zero. `SQ_HOLD` returns to `SQ_IDLE` after one cycle. From any state, the sequencer returns to `SQ_IDLE` whenever the control register is being written with manual enable set, or already holds it set.

Top module: `cam_bus_ctrl`

## Requirements
- R1: After reset the control register reads 0, the speed register reads 27h, both status halves read 0, all four CAM lines are high, cam_d_oe is 0 and auto_busy is 0.
- R2: While control bit 4 is 0, bits 3:0 have no effect on the CAM lines. The lines then come from the sequencer: all high when idle, and chip enable still low during an active strobe.
- R3: One cycle after a control write with bit 4 set, the lines equal the written bits: bit 0 to cam_ec_n, bit 1 to cam_cm_n, bit 2 to cam_w_n, bit 3 to cam_e_n.
- R4: In manual mode cam_d_oe is 1 only while both cam_w_n and cam_e_n are low, and cam_d_out then carries the data register (address 1). Otherwise cam_d_oe is 0.
- R5: In manual mode, the first clock edge at which chip enable is high, having been low in the previous cycle while write enable was high, loads cam_d_in into one status half. Control bit 5 picks the half: 0 selects the low half at address 2, 1 selects the high half at address 3. The other half keeps its value.
- R6: The speed register (address 4) accepts only the codes 27h, 25h and 20h. A write of any other code leaves it unchanged.
- R7: An auto_req sampled in SQ_IDLE with manual mode off starts an access. It gives one cycle with chip enable high, then chip enable low for exactly speed-code cycles, then one cycle with chip enable high and auto_done high. cam_ec_n is low throughout, and auto_busy is high for speed+2 cycles.
- R8: A control write that sets bit 4 aborts a running access at the same clock edge, and no auto_done follows. An auto_req in the same cycle as such a write, or while manual mode is on, is dropped.
- R9: During an auto access with auto_wr set, cam_w_n is low and cam_d_out carries auto_data. cam_d_oe is high exactly in the strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_addr | input | 3 | Register address: 0 control, 1 data, 2 status low, 3 status high, 4 speed |
| hst_we | input | 1 | Register write strobe |
| hst_wdata | input | 16 | Register write data |
| hst_rdata | output | 16 | Register read data for hst_addr (combinational) |
| auto_req | input | 1 | Start one automatic access |
| auto_cmd | input | 1 | Automatic access is a command cycle |
| auto_wr | input | 1 | Automatic access is a write |
| auto_data | input | 16 | Data driven in an automatic write |
| auto_busy | output | 1 | Sequencer not idle |
| auto_done | output | 1 | Last cycle of an automatic access |
| cam_ec_n | output | 1 | Chain enable, active low |
| cam_cm_n | output | 1 | Command mode, active low |
| cam_w_n | output | 1 | Write enable, active low |
| cam_e_n | output | 1 | Chip enable, active low |
| cam_d_out | output | 16 | Data bus drive value |
| cam_d_oe | output | 1 | Data bus drive enable |
| cam_d_in | input | 16 | Data bus sampled value |

## Verification
Two functions can meet in one cycle: the host's manual takeover and the sequencer's handling of a request. The bench raises auto_req in the same cycle as a control write of 1Fh and expects no access to start, either then or after manual mode is cleared again. It also takes the bus over in the middle of a strobe. There it expects the lines to follow the register on the next cycle, auto_busy to fall and auto_done to stay low. A control write with bit 4 clear during a strobe checks that chip enable stays under the sequencer's control.

// File: rtl/cam_bus_pkg.sv
package cam_bus_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int SPD_W  = 6;
    localparam int CTRL_W = 6;

    // control register bit positions (lines are active low)
    localparam int CB_EC  = 0;
    localparam int CB_CM  = 1;
    localparam int CB_W   = 2;
    localparam int CB_E   = 3;
    localparam int CB_MAN = 4;
    localparam int CB_SEL = 5;

    localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] RA_DATA  = 3'd1;
    localparam logic [ADDR_W-1:0] RA_STLO  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_STHI  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_SPEED = 3'd4;

    localparam logic [SPD_W-1:0] SPD_SLOW = 6'h27;
    localparam logic [SPD_W-1:0] SPD_MID  = 6'h25;
    localparam logic [SPD_W-1:0] SPD_FAST = 6'h20;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETUP  = 2'd1,
        SQ_STROBE = 2'd2,
        SQ_HOLD   = 2'd3
    } seq_state_t;

    function automatic logic speed_ok(input logic [SPD_W-1:0] code);
        return (code == SPD_SLOW) || (code == SPD_MID) || (code == SPD_FAST);
    endfunction

endpackage

// File: rtl/cam_host_regs.sv
module cam_host_regs
    import cam_bus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int SW = SPD_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] hst_addr,
    input  logic          hst_we,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic [DW-1:0] cam_d_in,
    output logic [CW-1:0] ctrl_q,
    output logic          man_en_d,
    output logic [DW-1:0] data_q,
    output logic [SW-1:0] speed_q
);

    localparam int NHALF = 2;

    logic [CW-1:0] ctrl_r;
    logic [DW-1:0] data_r;
    logic [SW-1:0] speed_r;
    logic [DW-1:0] stat_r [NHALF];
    logic          e_q, w_q, man_q;
    logic          wr_ctrl, wr_data, wr_speed, capture;

    assign wr_ctrl  = hst_we && (hst_addr == RA_CTRL);
    assign wr_data  = hst_we && (hst_addr == RA_DATA);
    assign wr_speed = hst_we && (hst_addr == RA_SPEED) && speed_ok(hst_wdata[SW-1:0]);
    assign man_en_d = wr_ctrl ? hst_wdata[CB_MAN] : ctrl_r[CB_MAN];

    // rising chip enable after a manual read strobe
    assign capture = ctrl_r[CB_MAN] && man_q && ctrl_r[CB_E] && !e_q && w_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_r  <= '0;
            data_r  <= '0;
            speed_r <= SPD_SLOW;
            e_q     <= 1'b1;
            w_q     <= 1'b1;
            man_q   <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl_r  <= hst_wdata[CW-1:0];
            if (wr_data)  data_r  <= hst_wdata;
            if (wr_speed) speed_r <= hst_wdata[SW-1:0];
            e_q   <= ctrl_r[CB_E];
            w_q   <= ctrl_r[CB_W];
            man_q <= ctrl_r[CB_MAN];
        end
    end

    for (genvar g = 0; g < NHALF; g++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_r[g] <= '0;
            else if (capture && (ctrl_r[CB_SEL] == 1'(g)))
                stat_r[g] <= cam_d_in;
        end
    end

    always_comb begin
        hst_rdata = '0;
        case (hst_addr)
            RA_CTRL:  hst_rdata = DW'(ctrl_r);
            RA_DATA:  hst_rdata = data_r;
            RA_STLO:  hst_rdata = stat_r[0];
            RA_STHI:  hst_rdata = stat_r[1];
            RA_SPEED: hst_rdata = DW'(speed_r);
            default:  hst_rdata = '0;
        endcase
    end

    assign ctrl_q  = ctrl_r;
    assign data_q  = data_r;
    assign speed_q = speed_r;

    // R6: only legal speed codes are ever held
    a_r6_speed_legal: assert property (@(posedge clk) disable iff (!rst_n)
        speed_ok(speed_r));

    // R5: a status half changes only at a capture edge
    a_r5_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(stat_r[0]) && $stable(stat_r[1])));

endmodule

// File: rtl/cam_auto_seq.sv
module cam_auto_seq
    import cam_bus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SPD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          man_en_d,
    input  logic [SW-1:0] speed,
    input  logic          req,
    input  logic          cmd,
    input  logic          wr,
    input  logic [DW-1:0] data_in,
    output logic [3:0]    seq_lines,
    output logic [DW-1:0] seq_d,
    output logic          seq_oe,
    output logic          busy,
    output logic          done
);

    seq_state_t    state_r, state_n;
    logic [SW-1:0] cnt_r;
    logic          cmd_r, wr_r;
    logic [DW-1:0] data_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= SQ_IDLE;
        else        state_r <= state_n;
    end

    // strobe counter and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_r  <= '0;
            cmd_r  <= 1'b0;
            wr_r   <= 1'b0;
            data_r <= '0;
        end else begin
            if (state_r == SQ_IDLE && req && !man_en_d) begin
                cmd_r  <= cmd;
                wr_r   <= wr;
                data_r <= data_in;
            end
            if (state_r == SQ_SETUP)
                cnt_r <= speed - SW'(1);
            else if (state_r == SQ_STROBE && cnt_r != '0)
                cnt_r <= cnt_r - SW'(1);
        end
    end

    // next state
    always_comb begin
        state_n = state_r;
        if (man_en_d) begin
            state_n = SQ_IDLE;
        end else begin
            unique case (state_r)
                SQ_IDLE:   if (req) state_n = SQ_SETUP;
                SQ_SETUP:  state_n = SQ_STROBE;
                SQ_STROBE: if (cnt_r == '0) state_n = SQ_HOLD;
                SQ_HOLD:   state_n = SQ_IDLE;
            endcase
        end
    end

    // outputs, lines ordered {e, w, cm, ec}
    always_comb begin
        seq_lines = 4'b1111;
        seq_oe    = 1'b0;
        seq_d     = data_r;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_r)
            SQ_IDLE: begin
                busy = 1'b0;
            end
            SQ_SETUP: begin
                seq_lines = {1'b1, ~wr_r, ~cmd_r, 1'b0};
            end
            SQ_STROBE: begin
                seq_lines = {1'b0, ~wr_r, ~cmd_r, 1'b0};
                seq_oe    = wr_r;
            end
            SQ_HOLD: begin
                seq_lines = {1'b1, ~wr_r, ~cmd_r, 1'b0};
                done      = 1'b1;
            end
        endcase
    end

    // R8: manual mode leaves the sequencer idle
    a_r8_idle_under_manual: assert property (@(posedge clk) disable iff (!rst_n)
        man_en_d |=> (state_r == SQ_IDLE));

    // R7: the hold cycle only follows a strobe
    a_r7_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == SQ_HOLD) |-> ($past(state_r) == SQ_STROBE));

    // R7: a strobe is entered only from setup
    a_r7_strobe_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == SQ_STROBE && $past(state_r) != SQ_STROBE) |-> ($past(state_r) == SQ_SETUP));

endmodule

// File: rtl/cam_bus_ctrl.sv
module cam_bus_ctrl
    import cam_bus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int SW = SPD_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] hst_addr,
    input  logic          hst_we,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic          auto_req,
    input  logic          auto_cmd,
    input  logic          auto_wr,
    input  logic [DW-1:0] auto_data,
    output logic          auto_busy,
    output logic          auto_done,
    output logic          cam_ec_n,
    output logic          cam_cm_n,
    output logic          cam_w_n,
    output logic          cam_e_n,
    output logic [DW-1:0] cam_d_out,
    output logic          cam_d_oe,
    input  logic [DW-1:0] cam_d_in
);

    localparam int NLINE = 4;

    logic [CW-1:0]    ctrl_q;
    logic             man_en_d, man;
    logic [DW-1:0]    data_q, seq_d;
    logic [SW-1:0]    speed_q;
    logic [NLINE-1:0] seq_lines, lines;
    logic             seq_oe;

    cam_host_regs #(.DW(DW), .AW(AW), .SW(SW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hst_addr  (hst_addr),
        .hst_we    (hst_we),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .cam_d_in  (cam_d_in),
        .ctrl_q    (ctrl_q),
        .man_en_d  (man_en_d),
        .data_q    (data_q),
        .speed_q   (speed_q)
    );

    cam_auto_seq #(.DW(DW), .SW(SW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .man_en_d  (man_en_d),
        .speed     (speed_q),
        .req       (auto_req),
        .cmd       (auto_cmd),
        .wr        (auto_wr),
        .data_in   (auto_data),
        .seq_lines (seq_lines),
        .seq_d     (seq_d),
        .seq_oe    (seq_oe),
        .busy      (auto_busy),
        .done      (auto_done)
    );

    assign man = ctrl_q[CB_MAN];

    // line order matches control bits 0..3: ec, cm, w, e
    logic [NLINE-1:0] seq_by_bit;
    assign seq_by_bit = {seq_lines[3], seq_lines[2], seq_lines[1], seq_lines[0]};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        assign lines[g] = man ? ctrl_q[g] : seq_by_bit[g];
    end

    assign cam_ec_n  = lines[CB_EC];
    assign cam_cm_n  = lines[CB_CM];
    assign cam_w_n   = lines[CB_W];
    assign cam_e_n   = lines[CB_E];
    assign cam_d_oe  = man ? (!ctrl_q[CB_W] && !ctrl_q[CB_E]) : seq_oe;
    assign cam_d_out = man ? data_q : seq_d;

    // R3: a manual control write shows on the lines one cycle later
    a_r3_lines_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_we && hst_addr == RA_CTRL && hst_wdata[CB_MAN])
        |=> ({cam_e_n, cam_w_n, cam_cm_n, cam_ec_n} == $past(hst_wdata[3:0])));

    // R4 / R9: the bus is only driven inside a write strobe
    a_r4_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cam_d_oe |-> (!cam_e_n && !cam_w_n));

endmodule

// File: tb/test_cam_bus_ctrl.sv
`timescale 1ns/1ps
module test_cam_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  hst_addr = '0;
    logic        hst_we = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        auto_req = 1'b0, auto_cmd = 1'b0, auto_wr = 1'b0;
    logic [15:0] auto_data = '0;
    logic        auto_busy, auto_done;
    logic        cam_ec_n, cam_cm_n, cam_w_n, cam_e_n, cam_d_oe;
    logic [15:0] cam_d_out;
    logic [15:0] cam_d_in = '0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cam_bus_ctrl i_cam_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .hst_addr(hst_addr), .hst_we(hst_we), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .auto_req(auto_req), .auto_cmd(auto_cmd), .auto_wr(auto_wr), .auto_data(auto_data),
        .auto_busy(auto_busy), .auto_done(auto_done),
        .cam_ec_n(cam_ec_n), .cam_cm_n(cam_cm_n), .cam_w_n(cam_w_n), .cam_e_n(cam_e_n),
        .cam_d_out(cam_d_out), .cam_d_oe(cam_d_oe), .cam_d_in(cam_d_in)
    );

    // {addr, wdata, lines {e,w,cm,ec}, oe, dout}
    localparam int NVEC = 11;
    localparam logic [39:0] VEC [NVEC] = '{
        {3'd1, 16'h0200, 4'b1111, 1'b0, 16'h0000},  // R2 load data, lines from idle sequencer
        {3'd0, 16'h0019, 4'b1001, 1'b0, 16'h0000},  // R3 chip enable high
        {3'd0, 16'h0011, 4'b0001, 1'b1, 16'h0200},  // R4 command write strobe
        {3'd0, 16'h0019, 4'b1001, 1'b0, 16'h0000},  // R3 chip enable high again
        {3'd0, 16'h000F, 4'b1111, 1'b0, 16'h0000},  // R2 bits ignored
        {3'd0, 16'h0000, 4'b1111, 1'b0, 16'h0000},  // R2
        {3'd1, 16'hABCD, 4'b1111, 1'b0, 16'h0000},  // data reload
        {3'd0, 16'h001B, 4'b1011, 1'b0, 16'h0000},  // R3
        {3'd0, 16'h0013, 4'b0011, 1'b1, 16'hABCD},  // R4 data write strobe
        {3'd0, 16'h0017, 4'b0111, 1'b0, 16'h0000},  // R4 read strobe, no drive
        {3'd0, 16'h0000, 4'b1111, 1'b0, 16'h0000}   // R2 back to sequencer
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {cam_e_n, cam_w_n, cam_cm_n, cam_ec_n};
    endfunction

    // drive at negedge, sample at the next negedge (after the write edge)
    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        hst_addr  = a;
        hst_wdata = d;
        hst_we    = 1'b1;
        @(negedge clk);
        hst_we    = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [15:0] d);
        hst_addr = a;
        #1;
        d = hst_rdata;
    endtask

    // one automatic access; checks R7 timing and R9 drive
    task automatic run_auto(input logic wr, input logic [15:0] d, input int spd);
        int lows = 0;
        int cycles = 1;
        int bad_drive = 0;
        int guard = 0;
        @(negedge clk);
        auto_req = 1'b1; auto_wr = wr; auto_cmd = 1'b0; auto_data = d;
        @(negedge clk);
        auto_req = 1'b0;
        check("R7 setup busy", auto_busy, 1);
        check("R7 setup e high, ec low", {cam_e_n, cam_ec_n}, 2'b10);
        while (!auto_done && guard < 300) begin
            @(negedge clk);
            guard++;
            cycles++;
            if (!cam_e_n) begin
                lows++;
                if (wr && !(cam_d_oe && cam_d_out == d && !cam_w_n)) bad_drive++;
            end else if (cam_d_oe) bad_drive++;
        end
        check("R7 strobe length", lows, spd);
        check("R7 busy length", cycles, spd + 2);
        check("R9 write drive", bad_drive, 0);
        @(negedge clk);
        check("R7 idle after", {auto_busy, auto_done, pins()}, {2'b00, 4'b1111});
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 lines", pins(), 4'b1111);
        check("R1 oe/busy", {cam_d_oe, auto_busy}, 2'b00);
        host_read(3'd0, rd); check("R1 ctrl", rd, 16'h0000);
        host_read(3'd4, rd); check("R1 speed", rd, 16'h0027);
        host_read(3'd2, rd); check("R1 status low", rd, 16'h0000);
        host_read(3'd3, rd); check("R1 status high", rd, 16'h0000);

        // vector table: manual pin control
        for (int i = 0; i < NVEC; i++) begin
            host_write(VEC[i][39:37], VEC[i][36:21]);
            check($sformatf("R3/R4 vec%0d lines", i), pins(), VEC[i][20:17]);
            check($sformatf("R4 vec%0d oe", i), cam_d_oe, VEC[i][16]);
            if (VEC[i][16]) check($sformatf("R4 vec%0d dout", i), cam_d_out, VEC[i][15:0]);
        end

        // R5 manual read into low half
        cam_d_in = 16'hA5C3;
        host_write(3'd0, 16'h001D);
        host_write(3'd0, 16'h0015);
        check("R4 read no drive", cam_d_oe, 0);
        host_write(3'd0, 16'h001D);
        @(negedge clk);
        host_read(3'd2, rd); check("R5 low half", rd, 16'hA5C3);
        host_read(3'd3, rd); check("R5 high untouched", rd, 16'h0000);
        // R5 high half
        cam_d_in = 16'h1234;
        host_write(3'd0, 16'h003D);
        host_write(3'd0, 16'h0035);
        host_write(3'd0, 16'h003D);
        @(negedge clk);
        host_read(3'd3, rd); check("R5 high half", rd, 16'h1234);
        host_read(3'd2, rd); check("R5 low kept", rd, 16'hA5C3);
        // rising edge after a write strobe captures nothing
        cam_d_in = 16'h7777;
        host_write(3'd0, 16'h0019);
        host_write(3'd0, 16'h0011);
        host_write(3'd0, 16'h0019);
        @(negedge clk);
        host_read(3'd2, rd); check("R5 no capture on write", rd, 16'hA5C3);
        host_write(3'd0, 16'h0000);

        // R6 speed codes
        host_write(3'd4, 16'h0025);
        host_read(3'd4, rd); check("R6 accept 25h", rd, 16'h0025);
        host_write(3'd4, 16'h002A);
        host_read(3'd4, rd); check("R6 reject 2Ah", rd, 16'h0025);
        host_write(3'd4, 16'h0000);
        host_read(3'd4, rd); check("R6 reject 00h", rd, 16'h0025);

        // R7 / R9 automatic accesses
        run_auto(1'b0, 16'h0000, 37);
        host_write(3'd4, 16'h0020);
        run_auto(1'b1, 16'hBEEF, 32);
        host_write(3'd4, 16'h0027);
        run_auto(1'b1, 16'h5A5A, 39);

        // R2 during strobe, then R8 abort
        @(negedge clk);
        auto_req = 1'b1; auto_wr = 1'b1; auto_data = 16'h0F0F;
        @(negedge clk);
        auto_req = 1'b0;
        repeat (4) @(negedge clk);
        host_write(3'd0, 16'h0007);
        check("R2 strobe kept", {cam_e_n, cam_d_oe}, 2'b01);
        host_write(3'd0, 16'h001F);
        check("R8 abort lines", pins(), 4'b1111);
        check("R8 abort busy", {auto_busy, cam_d_oe}, 2'b00);
        begin
            int seen = 0;
            repeat (50) begin
                @(negedge clk);
                if (auto_done || auto_busy) seen++;
            end
            check("R8 no done after abort", seen, 0);
        end
        host_write(3'd0, 16'h0000);

        // R8 request in the same cycle as a takeover write
        @(negedge clk);
        auto_req = 1'b1;
        hst_addr = 3'd0; hst_wdata = 16'h001F; hst_we = 1'b1;
        @(negedge clk);
        auto_req = 1'b0; hst_we = 1'b0;
        check("R8 same-cycle busy", auto_busy, 0);
        host_write(3'd0, 16'h0000);
        repeat (3) @(negedge clk);
        check("R8 request dropped", {auto_busy, pins()}, {1'b0, 4'b1111});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule